// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This unit collects the interrupt-related state of an SD host controller. Set pulses from the command path, the data path and the internal DMA engine, together with card insertion and removal events, land in a raw status register. Software masks that register, enables or disables the whole interrupt output through a control register, and acknowledges events by writing ones. A single level-sensitive interrupt line goes to the system interrupt controller.

The unit also owns the transfer byte accounting. Software loads a byte total, and the data path pulses once for every 32-bit word moved. When the remaining count runs out, the unit raises the data-complete status bit by itself. A separate DMA status word records transmit, receive and summary completion. It is acknowledged by writing ones, and only its low ten bits can be cleared that way.

Access goes through a simple single-cycle port with a 3-bit word address. Writes take effect on the clock edge. Read data is combinational from the current register state.

Top module: `sdh_irq_unit`

## Requirements
- R1: `irq` is high exactly when control bit 4 is set and the bitwise AND of raw status and mask is nonzero. It follows register state with no added cycle.
- R2: A read at address 2 returns raw status AND mask (mask at address 1, raw at address 3). A write at address 2 or address 3 clears every raw status bit where the written data has a one.
- R3: When a hardware set event and a software write-one-clear hit the same bit of raw status, card status or DMA status in the same cycle, the bit ends up set.
- R4: `card_in` sets raw bit 30, clears raw bit 31 and sets card status bit 8. `card_out` sets raw bit 31, clears raw bit 30 and clears card status bit 8. If both pulse together, the insertion takes effect.
- R5: The card status register at address 4 resets to 0x100. Writing ones to it clears those bits.
- R6: The control register at address 0 resets to 0x300. A write stores the data with bits 2, 1 and 0 forced to zero.
- R7: A write at address 6 loads both the byte total (read at address 6) and the remaining count (read-only, address 7). A load takes priority over a word move in the same cycle.
- R8: Each `word_moved` pulse lowers the remaining count by 4 and stops at zero. A move that leaves the count at zero (including a move when it is already zero) sets raw bit 3.
- R9: The DMA status register at address 5 gets bits 0 and 8 set by `dma_tx_done`, and bits 1 and 8 set by `dma_rx_done`. Writing ones clears only within bits 9 to 0. Ones written above bit 9 have no effect.
- R10: After reset, mask, raw status, DMA status and remaining count read 0, and the byte total reads 0x200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_set | input | 32 | One-cycle set pulses into raw status |
| word_moved | input | 1 | One data word transferred |
| dma_tx_done | input | 1 | DMA transmit completion pulse |
| dma_rx_done | input | 1 | DMA receive completion pulse |
| card_in | input | 1 | Card insertion event |
| card_out | input | 1 | Card removal event |
| irq | output | 1 | Level interrupt output |

## Verification
A hardware set pulse and a software write-one-clear can target the same status bit in the same cycle. This happens through `ev_set`, through the end of the byte count, through DMA completion and through card events. The bench provokes this directly by writing all ones to the raw, card and DMA addresses in the same cycle as the matching event. Its random phase also overlaps writes and events freely. In every case it reads the register back in the following cycle and expects the bit to be set. A load of the byte total and a word move can also meet in one cycle. The bench judges that case by reading the loaded value unchanged at the remaining-count address.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
    localparam int DW = 32;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        A_CTRL   = 3'd0,
        A_MASK   = 3'd1,
        A_MSTAT  = 3'd2,
        A_RAW    = 3'd3,
        A_CARD   = 3'd4,
        A_DMA    = 3'd5,
        A_BYTES  = 3'd6,
        A_REMAIN = 3'd7
    } reg_addr_e;

    localparam int EN_BIT        = 4;
    localparam int SELFCLR_W     = 3;
    localparam int RAW_DONE_BIT  = 3;
    localparam int RAW_INS_BIT   = 30;
    localparam int RAW_REM_BIT   = 31;
    localparam int CARD_PRES_BIT = 8;
    localparam int DMA_TX_BIT    = 0;
    localparam int DMA_RX_BIT    = 1;
    localparam int DMA_SUM_BIT   = 8;
    localparam int DMA_CLR_W     = 10;

    localparam logic [DW-1:0] CTRL_RST  = 32'h0000_0300;
    localparam logic [DW-1:0] CARD_RST  = 32'h0000_0100;
    localparam logic [DW-1:0] BYTES_RST = 32'h0000_0200;

    typedef struct packed {
        logic ctrl;
        logic mask;
        logic clr_raw;
        logic card;
        logic dma;
        logic bytes;
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(input logic wr, input logic [AW-1:0] a);
        wr_dec_t d;
        d = '0;
        if (wr) begin
            case (a)
                A_CTRL:         d.ctrl    = 1'b1;
                A_MASK:         d.mask    = 1'b1;
                A_MSTAT, A_RAW: d.clr_raw = 1'b1;
                A_CARD:         d.card    = 1'b1;
                A_DMA:          d.dma     = 1'b1;
                A_BYTES:        d.bytes   = 1'b1;
                default:        ;
            endcase
        end
        return d;
    endfunction
endpackage

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
    import sdh_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_mask,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] mask_q
);
    localparam logic [DW-1:0] KEEP = ~{{(DW-SELFCLR_W){1'b0}}, {SELFCLR_W{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata & KEEP;
            if (wr_mask) mask_q <= wdata;
        end
    end

    // R6
    ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> ctrl_q == ($past(wdata) & KEEP));
endmodule

// File: rtl/sdh_irq_raw.sv
module sdh_irq_raw
    import sdh_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ev_set,
    input  logic          done_set,
    input  logic          card_in,
    input  logic          card_out,
    input  logic          clr_raw,
    input  logic          wr_card,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] raw_q,
    output logic [DW-1:0] card_q
);
    logic [DW-1:0] set_v;
    logic [DW-1:0] clr_v;

    always_comb begin
        set_v = ev_set;
        clr_v = clr_raw ? wdata : '0;
        set_v[RAW_DONE_BIT] = set_v[RAW_DONE_BIT] | done_set;
        if (card_in) begin
            set_v[RAW_INS_BIT] = 1'b1;
            clr_v[RAW_REM_BIT] = 1'b1;
        end else if (card_out) begin
            set_v[RAW_REM_BIT] = 1'b1;
            clr_v[RAW_INS_BIT] = 1'b1;
        end
    end

    for (genvar b = 0; b < DW; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           raw_q[b] <= 1'b0;
            else if (set_v[b]) raw_q[b] <= 1'b1;
            else if (clr_v[b]) raw_q[b] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            card_q <= CARD_RST;
        end else begin
            card_q <= wr_card ? (card_q & ~wdata) : card_q;
            if (card_in)       card_q[CARD_PRES_BIT] <= 1'b1;
            else if (card_out) card_q[CARD_PRES_BIT] <= 1'b0;
        end
    end

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|ev_set) |=> ((raw_q & $past(ev_set)) == $past(ev_set)));
    // R2
    sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_raw |=> ((raw_q & $past(wdata & ~set_v)) == '0));
    // R4
    insert_chk: assert property (@(posedge clk) disable iff (rst)
        (card_in && !ev_set[RAW_REM_BIT]) |=> (raw_q[RAW_INS_BIT] && !raw_q[RAW_REM_BIT] && card_q[CARD_PRES_BIT]));
    // R4
    remove_chk: assert property (@(posedge clk) disable iff (rst)
        (card_out && !card_in && !ev_set[RAW_INS_BIT]) |=> (raw_q[RAW_REM_BIT] && !raw_q[RAW_INS_BIT] && !card_q[CARD_PRES_BIT]));
endmodule

// File: rtl/sdh_xfer_cnt.sv
module sdh_xfer_cnt #(
    parameter int CNT_W = 32,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] total_rst,
    input  logic             move,
    output logic [CNT_W-1:0] total_q,
    output logic [CNT_W-1:0] remain_q,
    output logic             done
);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    assign done = move && !load && (remain_q <= STEP_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q  <= total_rst;
            remain_q <= '0;
        end else if (load) begin
            total_q  <= load_val;
            remain_q <= load_val;
        end else if (move) begin
            remain_q <= (remain_q > STEP_V) ? remain_q - STEP_V : '0;
        end
    end

    // R8
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (move && !load && remain_q > STEP_V) |=> remain_q == $past(remain_q) - STEP_V);
    // R8
    done_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> remain_q == '0);
    // R7
    load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (remain_q == $past(load_val) && total_q == $past(load_val)));
endmodule

// File: rtl/sdh_dma_stat.sv
module sdh_dma_stat
    import sdh_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [DMA_CLR_W-1:0] clr_bits,
    input  logic                 tx_done,
    input  logic                 rx_done,
    output logic [DW-1:0]        stat_q
);
    logic [DW-1:0] clr_v;
    logic [DW-1:0] set_v;

    always_comb begin
        clr_v = '0;
        if (wr) clr_v[DMA_CLR_W-1:0] = clr_bits;
        set_v = '0;
        set_v[DMA_TX_BIT]  = tx_done;
        set_v[DMA_RX_BIT]  = rx_done;
        set_v[DMA_SUM_BIT] = tx_done | rx_done;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_v) | set_v;
    end

    // R9
    tx_flag_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> (stat_q[DMA_TX_BIT] && stat_q[DMA_SUM_BIT]));
    // R9
    rx_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> (stat_q[DMA_RX_BIT] && stat_q[DMA_SUM_BIT]));
    // R9
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stat_q[DW-1:DMA_CLR_W] == $past(stat_q[DW-1:DMA_CLR_W]));
endmodule

// File: rtl/sdh_irq_unit.sv
module sdh_irq_unit
    import sdh_irq_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] ev_set,
    input  logic          word_moved,
    input  logic          dma_tx_done,
    input  logic          dma_rx_done,
    input  logic          card_in,
    input  logic          card_out,
    output logic          irq
);
    wr_dec_t          dec;
    logic [DW-1:0]    ctrl_q, mask_q, raw_q, card_q, dma_q;
    logic [CNT_W-1:0] total_q, remain_q;
    logic             xfer_done;

    assign dec = decode_wr(reg_wr, reg_addr);

    sdh_irq_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .wr_ctrl(dec.ctrl), .wr_mask(dec.mask), .wdata(reg_wdata),
        .ctrl_q(ctrl_q), .mask_q(mask_q)
    );

    sdh_xfer_cnt #(.CNT_W(CNT_W), .STEP(WORD_BYTES)) u_cnt (
        .clk(clk), .rst(rst),
        .load(dec.bytes), .load_val(reg_wdata[CNT_W-1:0]),
        .total_rst(BYTES_RST[CNT_W-1:0]), .move(word_moved),
        .total_q(total_q), .remain_q(remain_q), .done(xfer_done)
    );

    sdh_irq_raw u_raw (
        .clk(clk), .rst(rst),
        .ev_set(ev_set), .done_set(xfer_done),
        .card_in(card_in), .card_out(card_out),
        .clr_raw(dec.clr_raw), .wr_card(dec.card), .wdata(reg_wdata),
        .raw_q(raw_q), .card_q(card_q)
    );

    sdh_dma_stat u_dma (
        .clk(clk), .rst(rst),
        .wr(dec.dma), .clr_bits(reg_wdata[DMA_CLR_W-1:0]),
        .tx_done(dma_tx_done), .rx_done(dma_rx_done),
        .stat_q(dma_q)
    );

    assign irq = ctrl_q[EN_BIT] & (|(raw_q & mask_q));

    always_comb begin
        case (reg_addr)
            A_CTRL:   reg_rdata = ctrl_q;
            A_MASK:   reg_rdata = mask_q;
            A_MSTAT:  reg_rdata = raw_q & mask_q;
            A_RAW:    reg_rdata = raw_q;
            A_CARD:   reg_rdata = card_q;
            A_DMA:    reg_rdata = dma_q;
            A_BYTES:  reg_rdata = DW'(total_q);
            default:  reg_rdata = DW'(remain_q);
        endcase
    end

    // R1
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[EN_BIT]) |=> !irq);
    // R1
    mask_off_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_MASK && reg_wdata == '0) |=> !irq);
endmodule

// File: tb/sim_sdh_irq_unit.sv
module sim_sdh_irq_unit;
    import sdh_irq_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst;
    logic          reg_wr;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;
    logic [DW-1:0] ev_set;
    logic          word_moved, dma_tx_done, dma_rx_done, card_in, card_out;
    logic          irq;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    logic [31:0] m_ctrl, m_mask, m_raw, m_card, m_dma, m_bytes, m_rem;

    sdh_irq_unit u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_set(ev_set),
        .word_moved(word_moved), .dma_tx_done(dma_tx_done),
        .dma_rx_done(dma_rx_done), .card_in(card_in), .card_out(card_out),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R6 ctrl";
            3'd1, 3'd2, 3'd3: return "R2 status";
            3'd4: return "R5 card";
            3'd5: return "R9 dma";
            3'd6: return "R7 bytes";
            default: return "R8 remain";
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_mask;
            3'd2: return m_raw & m_mask;
            3'd3: return m_raw;
            3'd4: return m_card;
            3'd5: return m_dma;
            3'd6: return m_bytes;
            default: return m_rem;
        endcase
    endfunction

    task automatic m_reset();
        m_ctrl = 32'h300; m_mask = 0; m_raw = 0; m_card = 32'h100;
        m_dma = 0; m_bytes = 32'h200; m_rem = 0;
    endtask

    task automatic m_update();
        logic [31:0] swc, setv, hwc;
        logic        ld, dn;
        ld = reg_wr && reg_addr == 3'd6;
        dn = word_moved && !ld && (m_rem <= 4);
        swc  = (reg_wr && (reg_addr == 3'd2 || reg_addr == 3'd3)) ? reg_wdata : 32'h0;
        setv = ev_set | (dn ? 32'h8 : 32'h0);
        hwc  = 32'h0;
        if (card_in) begin setv |= 32'h4000_0000; hwc = 32'h8000_0000; end
        else if (card_out) begin setv |= 32'h8000_0000; hwc = 32'h4000_0000; end
        m_raw = (m_raw & ~(swc | hwc)) | setv;
        if (reg_wr && reg_addr == 3'd4) m_card &= ~reg_wdata;
        if (card_in) m_card[8] = 1'b1;
        else if (card_out) m_card[8] = 1'b0;
        if (reg_wr && reg_addr == 3'd5) m_dma &= ~{22'h0, reg_wdata[9:0]};
        if (dma_tx_done) m_dma |= 32'h101;
        if (dma_rx_done) m_dma |= 32'h102;
        if (reg_wr && reg_addr == 3'd0) m_ctrl = reg_wdata & ~32'h7;
        if (reg_wr && reg_addr == 3'd1) m_mask = reg_wdata;
        if (ld) begin m_bytes = reg_wdata; m_rem = reg_wdata; end
        else if (word_moved) m_rem = (m_rem > 4) ? m_rem - 4 : 0;
    endtask

    task automatic idle_in();
        reg_wr = 0; reg_wdata = 0; ev_set = 0; word_moved = 0;
        dma_tx_done = 0; dma_rx_done = 0; card_in = 0; card_out = 0;
    endtask

    // one clock: inputs already applied at negedge; compare after update
    task automatic step();
        @(posedge clk);
        if (rst) m_reset(); else m_update();
        @(negedge clk);
        chk("R1 irq", {31'h0, irq}, {31'h0, m_ctrl[4] && ((m_raw & m_mask) != 0)});
        chk(tag_of(reg_addr), reg_rdata, m_read(reg_addr));
        idle_in();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_in();
        reg_addr = 0;
        rst = 1;
        @(negedge clk);
        step();
        step();
        rst = 0;
        step();

        // R10 R6 R5 reset values
        rd_expect(3'd0, 32'h300, "R6 reset ctrl");
        rd_expect(3'd1, 32'h0, "R10 reset mask");
        rd_expect(3'd3, 32'h0, "R10 reset raw");
        rd_expect(3'd4, 32'h100, "R5 reset card");
        rd_expect(3'd5, 32'h0, "R10 reset dma");
        rd_expect(3'd6, 32'h200, "R10 reset bytes");
        rd_expect(3'd7, 32'h0, "R10 reset remain");
        chk("R1 reset irq", {31'h0, irq}, 32'h0);

        // R3 set beats clear on raw
        wr(3'd3, 32'hFFFF_FFFF); ev_set = 32'h20; step();
        rd_expect(3'd3, 32'h20, "R3 raw collision");

        // R1 mask and enable
        wr(3'd1, 32'h20); step();
        chk("R1 enable off", {31'h0, irq}, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF); step();
        rd_expect(3'd0, 32'hFFFF_FFF8, "R6 self clear bits");
        chk("R1 enabled", {31'h0, irq}, 32'h1);
        rd_expect(3'd2, 32'h20, "R2 masked read");
        wr(3'd2, 32'h20); step();
        rd_expect(3'd3, 32'h0, "R2 clear via masked addr");
        chk("R1 cleared", {31'h0, irq}, 32'h0);

        // R4 card events
        card_out = 1; step();
        rd_expect(3'd3, 32'h8000_0000, "R4 remove raw");
        rd_expect(3'd4, 32'h0, "R4 remove card");
        card_in = 1; step();
        rd_expect(3'd3, 32'h4000_0000, "R4 insert raw");
        rd_expect(3'd4, 32'h100, "R4 insert card");
        card_out = 1; step();
        card_in = 1; card_out = 1; step();
        rd_expect(3'd3, 32'h4000_0000, "R4 both insert wins");
        wr(3'd4, 32'hFFFF_FFFF); step();
        rd_expect(3'd4, 32'h0, "R5 card w1c");
        wr(3'd4, 32'hFFFF_FFFF); card_in = 1; step();
        rd_expect(3'd4, 32'h100, "R3 card collision");
        wr(3'd3, 32'hFFFF_FFFF); step();

        // R7 R8 byte counting
        wr(3'd6, 32'd9); step();
        rd_expect(3'd6, 32'd9, "R7 total load");
        rd_expect(3'd7, 32'd9, "R7 remain load");
        word_moved = 1; step();
        rd_expect(3'd7, 32'd5, "R8 minus four");
        word_moved = 1; step();
        rd_expect(3'd3, 32'h0, "R8 not yet done");
        word_moved = 1; step();
        rd_expect(3'd7, 32'd0, "R8 saturate");
        rd_expect(3'd3, 32'h8, "R8 done set");
        wr(3'd3, 32'h8); step();
        word_moved = 1; step();
        rd_expect(3'd3, 32'h8, "R8 done at zero");
        wr(3'd3, 32'h8); word_moved = 1; step();
        rd_expect(3'd3, 32'h8, "R3 done collision");
        wr(3'd6, 32'd20); word_moved = 1; step();
        rd_expect(3'd7, 32'd20, "R7 load beats move");
        wr(3'd3, 32'hFFFF_FFFF); step();

        // R9 dma status
        dma_tx_done = 1; step();
        rd_expect(3'd5, 32'h101, "R9 tx");
        dma_rx_done = 1; step();
        rd_expect(3'd5, 32'h103, "R9 rx");
        wr(3'd5, 32'hFFFF_FC00); step();
        rd_expect(3'd5, 32'h103, "R9 upper write ignored");
        wr(3'd5, 32'h1); step();
        rd_expect(3'd5, 32'h102, "R9 clear tx");
        wr(3'd5, 32'h3FF); dma_tx_done = 1; step();
        rd_expect(3'd5, 32'h101, "R3 dma collision");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            reg_addr = 3'($urandom);
            if (($urandom % 4) == 0) begin
                reg_wr = 1;
                reg_wdata = (reg_addr == 3'd6) ? ($urandom % 40) : $urandom;
                if (reg_addr == 3'd1) reg_wdata = reg_wdata & ~32'hC000_0000;
            end
            ev_set      = $urandom & $urandom & $urandom & $urandom;
            word_moved  = ($urandom % 3) == 0;
            dma_tx_done = ($urandom % 16) == 0;
            dma_rx_done = ($urandom % 16) == 0;
            card_in     = ($urandom % 16) == 0;
            card_out    = ($urandom % 16) == 0;
            step();
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule